// File: doc/BRIEF.md
# Descriptor-Fetch DMA Engine for a Flash Controller

This block is the internal DMA mover of a flash controller. Software places a four-word descriptor in memory and loads the descriptor's address into the engine's base register. On a start pulse, the engine fetches the descriptor over a simple request/acknowledge memory port and checks it. It then moves one buffer between memory and a 64-bit byte stream, one 8-byte beat at a time. The direction comes from the command that started the transfer. A transmit transfer reads memory and feeds the outgoing stream toward the flash. A receive transfer accepts beats from the incoming stream and writes them to memory.

The descriptor words sit at base+0 (status), base+4 (sizes), base+8 (buffer address) and base+12 (a second pointer, which the engine never reads). When the buffer has been moved, the engine writes the status word back with its ownership bit cleared, which hands the descriptor back to software. It then pulses a completion event for the direction used. A descriptor that the engine may not use raises a separate unavailable event, and no data moves.

Top module: `flash_dma_fetch`

## Requirements
- R1: A write on `base_we` loads `base_wdata` into the base register. A transfer reads the descriptor at base, then base+4, then base+8, in that order. Each read takes the word from `mem_rdata[31:0]`.
- R2: `start` is taken only while `busy` is low. A `start` pulse during a transfer adds no memory access, no beat and no event.
- R3: If status bit 31 (ownership) is 0, only the status word is read. `evt_no_desc` pulses once. No beat, no writeback and no completion event follow.
- R4: Status bits 3 (first) and 2 (last) must both be 1. Otherwise the descriptor is treated exactly as in R3.
- R5: The byte count is bits 11:0 of the sizes word, and bits 31:12 are ignored. The transfer has ceil(count/8) beats, and beat k uses address ptr+8k.
- R6: With `start_tx`=1, every beat is a memory read at its address whose data appears unchanged on `tx_data`.
- R7: With `start_tx`=0, every beat accepted from `rx_data` is written unchanged to memory at its address.
- R8: The byte enables of a beat (`tx_be`, and `mem_be` on data writes) are 8'hFF. The exception is the final beat when count mod 8 = m is nonzero: its enables are the low m bits set.
- R9: After the last beat, one write goes to the base address with `mem_be`=8'h0F. Its `mem_wdata[31:0]` is the fetched status with bit 31 cleared.
- R10: Acknowledgement of the writeback pulses `evt_tx_done` (transmit) or `evt_rx_done` (receive) for one cycle, and `busy` drops. A count of 0 gives no beats but still writes back and completes. At most one event is high at a time.
- R11: `mem_req` keeps its address and `mem_we` until `mem_ack`, and `tx_valid` keeps its data until `tx_ready`.
- R12: After reset, `busy`, `mem_req`, `tx_valid`, `rx_ready` and all events are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Load the descriptor base register |
| base_wdata | input | 32 | New descriptor base address |
| start | input | 1 | Begin a transfer (idle only) |
| start_tx | input | 1 | 1 = memory to flash, 0 = flash to memory |
| busy | output | 1 | Transfer in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Write byte enables |
| mem_ack | input | 1 | Access completed (read data valid) |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Outgoing beat valid |
| tx_data | output | 64 | Outgoing beat |
| tx_be | output | 8 | Valid bytes of outgoing beat |
| tx_ready | input | 1 | Outgoing beat accepted |
| rx_valid | input | 1 | Incoming beat valid |
| rx_data | input | 64 | Incoming beat |
| rx_ready | output | 1 | Engine can take an incoming beat |
| evt_tx_done | output | 1 | Transmit buffer done pulse |
| evt_rx_done | output | 1 | Receive buffer done pulse |
| evt_no_desc | output | 1 | Descriptor unavailable pulse |

## Verification
The main function is swept over every byte count from 0 to 40 and over the 4095 maximum, in both directions. This exposes the rounding of the beat count and the byte enables at each remainder mod 8, and it separates the zero-length case from a one-beat transfer. The stream handshakes run with three ready/valid duty patterns, so that a beat counted twice or dropped shows as a wrong data order. The sizes word carries junk above bit 11. Status words that lack ownership, the first flag or the last flag show whether each flag is checked separately. A start pulse of the opposite direction during a transfer tests that the command is ignored while busy. Moving the base register between runs shows that descriptor and writeback addresses follow it.

// File: rtl/flash_dma_fetch.sv
module flash_dma_fetch #(
  parameter int AW         = 32,
  parameter int BEAT_BYTES = 8,
  parameter int SIZE_W     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_we,
  input  logic [AW-1:0]           base_wdata,
  input  logic                    start,
  input  logic                    start_tx,
  output logic                    busy,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [BEAT_BYTES*8-1:0] mem_wdata,
  output logic [BEAT_BYTES-1:0]   mem_be,
  input  logic                    mem_ack,
  input  logic [BEAT_BYTES*8-1:0] mem_rdata,
  output logic                    tx_valid,
  output logic [BEAT_BYTES*8-1:0] tx_data,
  output logic [BEAT_BYTES-1:0]   tx_be,
  input  logic                    tx_ready,
  input  logic                    rx_valid,
  input  logic [BEAT_BYTES*8-1:0] rx_data,
  output logic                    rx_ready,
  output logic                    evt_tx_done,
  output logic                    evt_rx_done,
  output logic                    evt_no_desc
);
  localparam int DW     = BEAT_BYTES * 8;
  localparam int OFF_W  = $clog2(BEAT_BYTES);
  localparam int BEAT_W = SIZE_W - OFF_W + 1;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_SIZE, S_PTR, S_MRD, S_TXO, S_RXI, S_MWR, S_WB
  } state_t;

  state_t              state;
  logic [AW-1:0]       base_q, ptr_q;
  logic [31:0]         stat_q;
  logic [SIZE_W-1:0]   size_q;
  logic [BEAT_W-1:0]   beat_q;
  logic                dir_tx_q;
  logic [DW-1:0]       buf_q;

  logic [OFF_W-1:0]      tail;
  logic [BEAT_W-1:0]     nbeats;
  logic                  last_beat;
  logic [BEAT_BYTES-1:0] beat_mask;
  logic [AW-1:0]         beat_addr;
  logic                  desc_ok;

  assign tail      = size_q[OFF_W-1:0];
  assign nbeats    = BEAT_W'(size_q[SIZE_W-1:OFF_W]) + BEAT_W'(|tail);
  assign last_beat = (beat_q + BEAT_W'(1)) == nbeats;
  assign beat_mask = (last_beat && tail != '0) ? ~({BEAT_BYTES{1'b1}} << tail)
                                               : {BEAT_BYTES{1'b1}};
  assign beat_addr = ptr_q + (AW'(beat_q) << OFF_W);
  assign desc_ok   = mem_rdata[31] && mem_rdata[3] && mem_rdata[2];

  assign busy     = state != S_IDLE;
  assign mem_req  = state inside {S_STAT, S_SIZE, S_PTR, S_MRD, S_MWR, S_WB};
  assign mem_we   = state inside {S_MWR, S_WB};
  assign tx_valid = state == S_TXO;
  assign rx_ready = state == S_RXI;
  assign tx_data  = buf_q;
  assign tx_be    = beat_mask;

  always_comb begin
    unique case (state)
      S_STAT:       mem_addr = base_q;
      S_SIZE:       mem_addr = base_q + AW'(4);
      S_PTR:        mem_addr = base_q + AW'(8);
      S_MRD, S_MWR: mem_addr = beat_addr;
      default:      mem_addr = base_q;
    endcase
  end

  assign mem_wdata = (state == S_WB) ? {{(DW-32){1'b0}}, stat_q & 32'h7FFF_FFFF} : buf_q;
  assign mem_be    = (state == S_WB) ? {{(BEAT_BYTES-4){1'b0}}, 4'hF} : beat_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      base_q      <= '0;
      ptr_q       <= '0;
      stat_q      <= '0;
      size_q      <= '0;
      beat_q      <= '0;
      dir_tx_q    <= 1'b0;
      buf_q       <= '0;
      evt_tx_done <= 1'b0;
      evt_rx_done <= 1'b0;
      evt_no_desc <= 1'b0;
    end else begin
      evt_tx_done <= 1'b0;
      evt_rx_done <= 1'b0;
      evt_no_desc <= 1'b0;
      if (base_we) base_q <= base_wdata;
      unique case (state)
        S_IDLE: if (start) begin
          dir_tx_q <= start_tx;
          state    <= S_STAT;
        end
        S_STAT: if (mem_ack) begin
          stat_q <= mem_rdata[31:0];
          if (desc_ok) state <= S_SIZE;
          else begin
            evt_no_desc <= 1'b1;
            state       <= S_IDLE;
          end
        end
        S_SIZE: if (mem_ack) begin
          size_q <= mem_rdata[SIZE_W-1:0];
          state  <= S_PTR;
        end
        S_PTR: if (mem_ack) begin
          ptr_q  <= mem_rdata[AW-1:0];
          beat_q <= '0;
          if (nbeats == '0) state <= S_WB;
          else              state <= dir_tx_q ? S_MRD : S_RXI;
        end
        S_MRD: if (mem_ack) begin
          buf_q <= mem_rdata;
          state <= S_TXO;
        end
        S_TXO: if (tx_ready) begin
          if (last_beat) state <= S_WB;
          else begin
            beat_q <= beat_q + BEAT_W'(1);
            state  <= S_MRD;
          end
        end
        S_RXI: if (rx_valid) begin
          buf_q <= rx_data;
          state <= S_MWR;
        end
        S_MWR: if (mem_ack) begin
          if (last_beat) state <= S_WB;
          else begin
            beat_q <= beat_q + BEAT_W'(1);
            state  <= S_RXI;
          end
        end
        S_WB: if (mem_ack) begin
          if (dir_tx_q) evt_tx_done <= 1'b1;
          else          evt_rx_done <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r10_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_tx_done, evt_rx_done, evt_no_desc}));

  a_r10_evt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_tx_done || evt_rx_done || evt_no_desc) |-> !busy);

  a_r8_low_lane: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_be[0]);
endmodule

// File: tb/flash_dma_fetch_tb.sv
module flash_dma_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        start = 1'b0;
  logic        start_tx = 1'b0;
  logic        busy;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [7:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        tx_valid;
  logic [63:0] tx_data;
  logic [7:0]  tx_be;
  logic        tx_ready = 1'b0;
  logic        rx_valid = 1'b0;
  logic [63:0] rx_data = '0;
  logic        rx_ready;
  logic        evt_tx_done, evt_rx_done, evt_no_desc;

  flash_dma_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .start(start), .start_tx(start_tx), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_be(tx_be), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_ready(rx_ready), .evt_tx_done(evt_tx_done),
    .evt_rx_done(evt_rx_done), .evt_no_desc(evt_no_desc)
  );

  initial forever #10 clk = ~clk;

  logic [31:0] d_base, d_stat, d_size, d_ptr;
  int          mode;
  logic [31:0] la [0:2047];
  logic        lwe [0:2047];
  logic [7:0]  lbe [0:2047];
  logic [63:0] lwd [0:2047];
  logic [63:0] ltd [0:2047];
  logic [7:0]  ltb [0:2047];
  int nacc = 0, ntx = 0, rx_cnt = 0, cyc = 0;
  int ev_tx = 0, ev_rx = 0, ev_no = 0;
  int nchk = 0, nfail = 0;

  function automatic logic [63:0] memval(logic [31:0] a);
    return {a ^ 32'h5A5A_0000, ~a};
  endfunction

  function automatic logic [63:0] rxpat(int i);
    return {32'(i) ^ 32'hC3C3_0000, 32'hBEEF_0000 + 32'(i)};
  endfunction

  function automatic bit gate(int m, int c);
    if (m == 0) return 1'b1;
    if (m == 1) return c[0];
    return (c % 3) == 0;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (evt_tx_done) ev_tx++;
    if (evt_rx_done) ev_rx++;
    if (evt_no_desc) ev_no++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      mem_ack = 1'b1;
      if (!mem_we) begin
        if      (mem_addr == d_base)         mem_rdata = {32'hDEAD_0000, d_stat};
        else if (mem_addr == d_base + 32'd4) mem_rdata = {32'hDEAD_0004, d_size};
        else if (mem_addr == d_base + 32'd8) mem_rdata = {32'hDEAD_0008, d_ptr};
        else                                 mem_rdata = memval(mem_addr);
      end
      if (nacc < 2048) begin
        la[nacc] = mem_addr; lwe[nacc] = mem_we; lbe[nacc] = mem_be; lwd[nacc] = mem_wdata;
      end
      nacc++;
    end
    tx_ready = gate(mode, cyc);
    if (tx_valid && tx_ready) begin
      if (ntx < 2048) begin ltd[ntx] = tx_data; ltb[ntx] = tx_be; end
      ntx++;
    end
    rx_valid = gate(mode, cyc + 1);
    rx_data  = rxpat(rx_cnt);
    if (rx_valid && rx_ready) rx_cnt++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(int k, int n, int sz);
    if (k == n - 1 && (sz % 8) != 0) return 8'((1 << (sz % 8)) - 1);
    return 8'hFF;
  endfunction

  task automatic set_base(input logic [31:0] v);
    @(negedge clk); base_we = 1'b1; base_wdata = v; d_base = v;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic run_xfer(input bit tx, input logic [31:0] st, input int sz,
                          input logic [31:0] p, input bit dup);
    int a0, t0, r0, e_tx, e_rx, e_no, n, g;
    bit ok;
    d_stat = st; d_size = {20'hABCDE, 12'(sz)}; d_ptr = p; mode = sz % 3;
    a0 = nacc; t0 = ntx; r0 = rx_cnt; e_tx = ev_tx; e_rx = ev_rx; e_no = ev_no;
    @(negedge clk); start = 1'b1; start_tx = tx;
    @(negedge clk); start = 1'b0;
    if (dup) begin
      repeat (6) @(negedge clk);
      start = 1'b1; start_tx = ~tx;
      @(negedge clk); start = 1'b0;
    end
    g = 0;
    while ((ev_tx + ev_rx + ev_no) == (e_tx + e_rx + e_no) && g < 20000) begin
      @(negedge clk); g++;
    end
    repeat (6) @(negedge clk);
    ok = st[31] && st[3] && st[2];
    n  = (sz + 7) / 8;
    chk(!busy, "R10 busy low after end", 64'(busy), 0);
    if (!ok) begin
      chk(ev_no - e_no == 1, "R3/R4 unavailable event", 64'(ev_no - e_no), 1);
      chk(nacc - a0 == 1, "R3/R4 only status read", 64'(nacc - a0), 1);
      chk(la[a0] == d_base && !lwe[a0], "R3 status read addr", 64'(la[a0]), 64'(d_base));
      chk(ntx == t0 && ev_tx == e_tx && ev_rx == e_rx, "R4 no beats or completion",
          64'(ntx - t0), 0);
    end else begin
      chk(nacc - a0 == 4 + n, "R5 access count", 64'(nacc - a0), 64'(4 + n));
      chk(la[a0] == d_base && la[a0+1] == d_base + 4 && la[a0+2] == d_base + 8 &&
          !lwe[a0] && !lwe[a0+1] && !lwe[a0+2], "R1 descriptor read order",
          64'(la[a0+1]), 64'(d_base + 4));
      for (int k = 0; k < n; k++) begin
        chk(la[a0+3+k] == p + 32'(8 * k) && lwe[a0+3+k] == !tx, "R5 beat address",
            64'(la[a0+3+k]), 64'(p + 32'(8 * k)));
        if (tx) begin
          chk(ltd[t0+k] == memval(p + 32'(8 * k)), "R6 tx data", ltd[t0+k], memval(p + 32'(8 * k)));
          chk(ltb[t0+k] == exp_be(k, n, sz), "R8 tx byte enables", 64'(ltb[t0+k]), 64'(exp_be(k, n, sz)));
        end else begin
          chk(lwd[a0+3+k] == rxpat(r0 + k), "R7 rx write data", lwd[a0+3+k], rxpat(r0 + k));
          chk(lbe[a0+3+k] == exp_be(k, n, sz), "R8 rx byte enables", 64'(lbe[a0+3+k]), 64'(exp_be(k, n, sz)));
        end
      end
      if (tx) chk(ntx - t0 == n, "R6 tx beat count", 64'(ntx - t0), 64'(n));
      else    chk(rx_cnt - r0 == n, "R7 rx beat count", 64'(rx_cnt - r0), 64'(n));
      chk(la[a0+3+n] == d_base && lwe[a0+3+n] && lbe[a0+3+n] == 8'h0F,
          "R9 writeback target", 64'(la[a0+3+n]), 64'(d_base));
      chk(lwd[a0+3+n][31:0] == (st & 32'h7FFF_FFFF), "R9 writeback status",
          64'(lwd[a0+3+n][31:0]), 64'(st & 32'h7FFF_FFFF));
      chk((ev_tx - e_tx) == int'(tx) && (ev_rx - e_rx) == int'(!tx) && ev_no == e_no,
          "R10 completion event", 64'(ev_tx - e_tx), 64'(tx));
      if (dup) chk(ev_rx == e_rx, "R2 start ignored while busy", 64'(ev_rx - e_rx), 0);
    end
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    d_base = '0; d_stat = '0; d_size = '0; d_ptr = '0; mode = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !tx_valid && !rx_ready &&
        !evt_tx_done && !evt_rx_done && !evt_no_desc, "R12 reset state",
        64'({busy, mem_req, tx_valid, rx_ready}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req, "R12 idle after reset", 64'({busy, mem_req}), 0);
    fork
      begin
        set_base(32'h1000_0100);
        for (int s = 0; s <= 40; s++)
          run_xfer(1'b1, 32'h8000_000C | 32'(s << 8), s, 32'h2000_0000 + 32'(s * 256), 1'b0);
        for (int s = 0; s <= 40; s++)
          run_xfer(1'b0, 32'hC000_000C, s, 32'h4000_0008 + 32'(s * 256), 1'b0);
        set_base(32'h3000_0040);
        run_xfer(1'b1, 32'h8000_000C, 4095, 32'h5000_0000, 1'b0);
        run_xfer(1'b1, 32'h0000_000C, 16, 32'h5000_0000, 1'b0);
        run_xfer(1'b0, 32'h8000_0004, 16, 32'h5000_0000, 1'b0);
        run_xfer(1'b1, 32'h8000_0008, 16, 32'h5000_0000, 1'b0);
        run_xfer(1'b1, 32'h8000_000C, 24, 32'h6000_0000, 1'b1);
        run_xfer(1'b0, 32'h8000_000C, 13, 32'h6000_1000, 1'b0);
      end
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      nchk++; nfail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule